// File: doc/BRIEF.md
# Endpoint-to-Staging Block Mover

The block moves received packet data out of eight endpoint FIFOs and into eight matching staging FIFOs. Each endpoint raises a request line once a received packet is waiting. The endpoint also reports how many bytes of that packet remain. The mover picks one requesting endpoint at a time in round-robin order and copies exactly one block per grant over a 32-bit datapath. A whole block is 64 bytes, or 16 beats. The read side is a show-ahead port: data for the selected endpoint is valid in the same cycle as the read strobe. Each beat is registered and written one cycle later into the staging FIFO with the same index.

An endpoint is granted only if its staging FIFO reports room for a whole block, which means at least 16 free entries. Once a block has started, it runs to the end without a pause. A drop of the request or a loss of room during the block does not stop it. When fewer than 64 bytes remain in a packet, the block is shortened. Every written beat carries the block's byte count and a flag that marks the packet's final block, so the logic downstream can find packet boundaries.

Top module: `ep_block_mover`

## Requirements
- R1: While reset is asserted and afterwards with no requests, `ep_rd_o` is 0 and `st_wr_o` is all zeros.
- R2: An endpoint `i` is granted only when `req_i[i]` is 1, `ep_bytes_i[i]` is non-zero and `st_free_i[i]` is 16 or more. A free count of exactly 16 is enough to start a block.
- R3: Arbitration is round-robin. After a block from endpoint k, the next grant goes to the first eligible endpoint after k in cyclic index order, and each grant moves one block. After reset, endpoint 0 has the highest priority.
- R4: A started block reads on consecutive cycles with `ep_sel_o` held constant until all of its beats are done. It is not cut short if the request drops or the free count falls below 16.
- R5: Each read beat on endpoint i appears one cycle later as a write on `st_wr_o[i]` with unchanged data. At most one bit of `st_wr_o` is set in any cycle.
- R6: If `ep_bytes_i` is 64 or more at grant, the block is 16 beats and `st_bytes_o` is 64 on every beat. `st_last_o` is 1 only when exactly 64 bytes remained.
- R7: If fewer than 64 bytes remain at grant, the block is ceil(bytes/4) beats. `st_bytes_o` equals the remaining bytes and `st_last_o` is 1.
- R8: Arbitration waits until the last write of the previous block has completed. Back-to-back blocks are therefore separated by exactly two cycles with `ep_rd_o` low.
- R9: An endpoint that is requesting is skipped if it has fewer than 16 free staging entries or reports zero bytes. Other eligible endpoints are still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CH | Per-endpoint data-waiting request |
| ep_bytes_i | input | N_CH x PKT_W | Bytes left in the current packet of each endpoint |
| ep_sel_o | output | CH_W | Endpoint FIFO select |
| ep_rd_o | output | 1 | Endpoint FIFO read strobe (show-ahead data) |
| ep_rdata_i | input | DATA_W | Head word of the selected endpoint FIFO |
| st_free_i | input | N_CH x FREE_W | Free entries in each staging FIFO |
| st_wr_o | output | N_CH | Per-channel staging FIFO write strobe |
| st_wdata_o | output | DATA_W | Staging write data |
| st_bytes_o | output | BB_W | Byte count of the block being written |
| st_last_o | output | 1 | Block ends the packet |

## Verification
The hardest case to reach is a block that has already started when its request is withdrawn and its staging room falls to zero. The stimulus waits until it sees the first read strobe of that block and changes both inputs in that same cycle. It then counts the beats that follow. Room boundaries are reached by setting one staging free count to 15 and then to 16 while a competing endpoint is served. Endpoints are loaded in groups so that the round-robin pointer has to wrap past index 7.

// File: rtl/mvr_pkg.sv
package mvr_pkg;
  typedef enum logic {MV_IDLE, MV_MOVE} mv_state_e;
endpackage

// File: rtl/mvr_rr_arb.sv
module mvr_rr_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  elig_i,
  input  logic          take_i,
  output logic          gnt_vld_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] last_q;

  always_comb begin
    int idx;
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!gnt_vld_o && elig_i[idx]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= IW'(N - 1);
    else if (take_i) last_q <= gnt_idx_o;
  end

  AST_GNT_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> elig_i[gnt_idx_o]); // R2
  AST_GNT_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|elig_i) |-> gnt_vld_o); // R3
endmodule

// File: rtl/mvr_blk_ctrl.sv
module mvr_blk_ctrl
  import mvr_pkg::*;
#(
  parameter int N_CH      = 8,
  parameter int DATA_W    = 32,
  parameter int BLK_BEATS = 16,
  parameter int PKT_W     = 11,
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int BPB       = DATA_W / 8,
  localparam int BLK_BYTES = BLK_BEATS * BPB,
  localparam int BB_W      = $clog2(BLK_BYTES + 1),
  localparam int BEAT_W    = $clog2(BLK_BEATS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_vld_i,
  input  logic [CH_W-1:0]  gnt_idx_i,
  input  logic [PKT_W-1:0] gnt_bytes_i,
  input  logic             wr_busy_i,
  output logic             take_o,
  output logic             rd_o,
  output logic [CH_W-1:0]  sel_o,
  output logic [BB_W-1:0]  bytes_o,
  output logic             last_o
);
  mv_state_e         state_q;
  logic [CH_W-1:0]   ch_q;
  logic [BEAT_W-1:0] left_q;
  logic [BB_W-1:0]   bytes_q;
  logic              last_q;
  logic              long_pkt;
  logic [BB_W-1:0]   blk_bytes_d;
  logic [BEAT_W-1:0] blk_beats_d;

  always_comb begin
    long_pkt    = gnt_bytes_i >= PKT_W'(BLK_BYTES);
    blk_bytes_d = long_pkt ? BB_W'(BLK_BYTES) : BB_W'(gnt_bytes_i);
    blk_beats_d = BEAT_W'((int'(blk_bytes_d) + BPB - 1) / BPB);
    // wait for the write stage to drain so the free counts are current
    take_o      = (state_q == MV_IDLE) && gnt_vld_i && !wr_busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MV_IDLE;
      ch_q    <= '0;
      left_q  <= '0;
      bytes_q <= '0;
      last_q  <= 1'b0;
    end else begin
      case (state_q)
        MV_IDLE: if (take_o) begin
          state_q <= MV_MOVE;
          ch_q    <= gnt_idx_i;
          left_q  <= blk_beats_d;
          bytes_q <= blk_bytes_d;
          last_q  <= gnt_bytes_i <= PKT_W'(BLK_BYTES);
        end
        MV_MOVE: begin
          left_q <= left_q - BEAT_W'(1);
          if (left_q == BEAT_W'(1)) state_q <= MV_IDLE;
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign rd_o    = (state_q == MV_MOVE);
  assign sel_o   = ch_q;
  assign bytes_o = bytes_q;
  assign last_o  = last_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && left_q > BEAT_W'(1)) |=> (rd_o && $stable(sel_o))); // R4
  AST_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_o) |=> !rd_o); // R8
  AST_BEAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (blk_beats_d != '0 && blk_beats_d <= BEAT_W'(BLK_BEATS))); // R7
endmodule

// File: rtl/mvr_wr_stage.sv
module mvr_wr_stage #(
  parameter int N_CH   = 8,
  parameter int DATA_W = 32,
  parameter int BB_W   = 7,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [CH_W-1:0]   sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BB_W-1:0]   bytes_i,
  input  logic              last_i,
  output logic              busy_o,
  output logic [N_CH-1:0]   wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BB_W-1:0]   bytes_o,
  output logic              last_o
);
  logic              vld_q;
  logic [CH_W-1:0]   ch_q;
  logic [DATA_W-1:0] data_q;
  logic [BB_W-1:0]   bytes_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      ch_q    <= '0;
      data_q  <= '0;
      bytes_q <= '0;
      last_q  <= 1'b0;
    end else begin
      vld_q <= rd_i;
      if (rd_i) begin
        ch_q    <= sel_i;
        data_q  <= data_i;
        bytes_q <= bytes_i;
        last_q  <= last_i;
      end
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_wr
    assign wr_o[g] = vld_q && (ch_q == CH_W'(g));
  end

  assign busy_o  = vld_q;
  assign wdata_o = data_q;
  assign bytes_o = bytes_q;
  assign last_o  = last_q;

  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o)); // R5
endmodule

// File: rtl/ep_block_mover.sv
module ep_block_mover #(
  parameter int N_CH      = 8,
  parameter int DATA_W    = 32,
  parameter int BLK_BEATS = 16,
  parameter int PKT_W     = 11,
  parameter int FREE_W    = 8,
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int BPB       = DATA_W / 8,
  localparam int BLK_BYTES = BLK_BEATS * BPB,
  localparam int BB_W      = $clog2(BLK_BYTES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CH-1:0]             req_i,
  input  logic [N_CH-1:0][PKT_W-1:0]  ep_bytes_i,
  output logic [CH_W-1:0]             ep_sel_o,
  output logic                        ep_rd_o,
  input  logic [DATA_W-1:0]           ep_rdata_i,
  input  logic [N_CH-1:0][FREE_W-1:0] st_free_i,
  output logic [N_CH-1:0]             st_wr_o,
  output logic [DATA_W-1:0]           st_wdata_o,
  output logic [BB_W-1:0]             st_bytes_o,
  output logic                        st_last_o
);
  logic [N_CH-1:0] elig;
  logic            gnt_vld;
  logic [CH_W-1:0] gnt_idx;
  logic            take;
  logic            wr_busy;
  logic [BB_W-1:0] blk_bytes;
  logic            blk_last;

  // whole-block room, not just one free slot
  for (genvar g = 0; g < N_CH; g++) begin : g_elig
    assign elig[g] = req_i[g] && (ep_bytes_i[g] != '0) &&
                     (st_free_i[g] >= FREE_W'(BLK_BEATS));
  end

  mvr_rr_arb #(.N(N_CH)) u_arb (
    .clk_i, .rst_ni,
    .elig_i    (elig),
    .take_i    (take),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx)
  );

  mvr_blk_ctrl #(
    .N_CH(N_CH), .DATA_W(DATA_W), .BLK_BEATS(BLK_BEATS), .PKT_W(PKT_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .gnt_vld_i   (gnt_vld),
    .gnt_idx_i   (gnt_idx),
    .gnt_bytes_i (ep_bytes_i[gnt_idx]),
    .wr_busy_i   (wr_busy),
    .take_o      (take),
    .rd_o        (ep_rd_o),
    .sel_o       (ep_sel_o),
    .bytes_o     (blk_bytes),
    .last_o      (blk_last)
  );

  mvr_wr_stage #(.N_CH(N_CH), .DATA_W(DATA_W), .BB_W(BB_W)) u_wr (
    .clk_i, .rst_ni,
    .rd_i    (ep_rd_o),
    .sel_i   (ep_sel_o),
    .data_i  (ep_rdata_i),
    .bytes_i (blk_bytes),
    .last_i  (blk_last),
    .busy_o  (wr_busy),
    .wr_o    (st_wr_o),
    .wdata_o (st_wdata_o),
    .bytes_o (st_bytes_o),
    .last_o  (st_last_o)
  );

  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_rd_o |=> (st_wr_o == (N_CH'(1) << $past(ep_sel_o)))); // R5
  AST_SHORT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|st_wr_o) && st_bytes_o < BB_W'(BLK_BYTES)) |-> st_last_o); // R7
  AST_IDLE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ep_rd_o && !$past(ep_rd_o)) |-> (st_wr_o == '0)); // R1
endmodule

// File: tb/ep_block_mover_tb_top.sv
`timescale 1ns/1ps
module ep_block_mover_tb_top;
  localparam int N = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      req;
  logic [N-1:0][10:0] ep_bytes;
  logic [2:0]        ep_sel;
  logic              ep_rd;
  logic [31:0]       ep_rdata;
  logic [N-1:0][7:0] st_free;
  logic [N-1:0]      st_wr;
  logic [31:0]       st_wdata;
  logic [6:0]        st_bytes;
  logic              st_last;

  always #10 clk = ~clk;

  logic [31:0] mem [N][64];
  logic [5:0]  rp [N];
  int rem_m [N];
  int free_m [N];
  bit req_mask [N];
  bit req_zero [N];
  int blk_left [N];
  int cur_by [N];
  bit cur_la [N];
  int rd_cnt [N];
  int pkt_seq = 1;

  int unsigned exp_ch [$];
  logic [31:0] exp_dat [$];
  int          exp_by [$];
  bit          exp_la [$];
  int          starts [$];
  int          exp_o [$];
  int gap_min, gap_max, idle_run;
  bit prev_rd, seen_fall;
  int n_chk = 0, n_bad = 0;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      req[c]      = ((rem_m[c] > 0) && !req_mask[c]) || req_zero[c];
      ep_bytes[c] = 11'(rem_m[c]);
      st_free[c]  = (free_m[c] < 0) ? 8'd0 : (free_m[c] > 255) ? 8'd255 : 8'(free_m[c]);
    end
  end
  assign ep_rdata = mem[ep_sel][rp[ep_sel]];

  ep_block_mover dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ep_bytes_i(ep_bytes),
    .ep_sel_o(ep_sel), .ep_rd_o(ep_rd), .ep_rdata_i(ep_rdata),
    .st_free_i(st_free), .st_wr_o(st_wr), .st_wdata_o(st_wdata),
    .st_bytes_o(st_bytes), .st_last_o(st_last)
  );

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor + scoreboard
  initial begin
    int c, wc, pop_ch, wr_ch;
    bit pop_now, wr_now;
    prev_rd = 0; seen_fall = 0; idle_run = 0;
    forever begin
      @(negedge clk);
      pop_now = 0; wr_now = 0; pop_ch = 0; wr_ch = 0;
      if (rst_n) begin
        if (ep_rd) begin
          c = int'(ep_sel);
          if (!prev_rd) begin
            starts.push_back(c);
            if (seen_fall) begin
              if (idle_run < gap_min) gap_min = idle_run;
              if (idle_run > gap_max) gap_max = idle_run;
            end
          end
          if (blk_left[c] == 0) begin
            cur_by[c] = (rem_m[c] >= 64) ? 64 : rem_m[c];
            cur_la[c] = (rem_m[c] <= 64);
            blk_left[c] = cur_by[c];
          end
          exp_ch.push_back(c); exp_dat.push_back(mem[c][rp[c]]);
          exp_by.push_back(cur_by[c]); exp_la.push_back(cur_la[c]);
          blk_left[c] -= (blk_left[c] >= 4) ? 4 : blk_left[c];
          rd_cnt[c]++;
          pop_now = 1; pop_ch = c;
        end else if (prev_rd) begin
          seen_fall = 1; idle_run = 1;
        end else idle_run++;
        prev_rd = ep_rd;
        if (st_wr != '0) begin
          wc = 0;
          for (int i = 0; i < N; i++) if (st_wr[i]) wc = i;
          wr_now = 1; wr_ch = wc;
          if (exp_ch.size() == 0) chk(0, "R5", "unexpected write", wc, 0);
          else begin
            int ech, eby; logic [31:0] ed; bit ela;
            ech = exp_ch.pop_front(); ed = exp_dat.pop_front();
            eby = exp_by.pop_front(); ela = exp_la.pop_front();
            chk($countones(st_wr) == 1 && wc == ech, "R5", "write channel", wc, ech);
            chk(st_wdata == ed, "R5", "write data", st_wdata, ed);
            chk(int'(st_bytes) == eby, (eby < 64) ? "R7" : "R6", "block bytes", st_bytes, eby);
            chk(st_last == ela, (eby < 64) ? "R7" : "R6", "last flag", st_last, ela);
          end
        end
      end
      @(posedge clk); #1;
      if (pop_now) begin
        rp[pop_ch] = rp[pop_ch] + 6'd1;
        rem_m[pop_ch] -= (rem_m[pop_ch] >= 4) ? 4 : rem_m[pop_ch];
      end
      if (wr_now) free_m[wr_ch]--;
    end
  end

  task automatic load_pkt(int c, int bytes);
    for (int i = 0; i < (bytes + 3) / 4; i++)
      mem[c][i] = {4'hC, 4'(c), 8'(pkt_seq), 16'(i * 7 + 1)};
    rp[c] = '0; blk_left[c] = 0; rem_m[c] = bytes;
    pkt_seq++;
  endtask

  task automatic clear_stats();
    for (int c = 0; c < N; c++) begin rd_cnt[c] = 0; free_m[c] = 64; end
    starts.delete(); gap_min = 999; gap_max = 0; seen_fall = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      quiet = (!ep_rd && st_wr == '0) ? quiet + 1 : 0;
    end
    chk(exp_ch.size() == 0, "R5", "scoreboard drained", exp_ch.size(), 0);
  endtask

  task automatic chk_order(string rq);
    bit ok = (starts.size() == exp_o.size());
    if (ok) foreach (exp_o[i]) if (starts[i] != exp_o[i]) ok = 0;
    chk(ok, rq, "grant order (first differing / count)", starts.size(), exp_o.size());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) begin
      rem_m[c] = 0; free_m[c] = 64; req_mask[c] = 0; req_zero[c] = 0;
      rp[c] = '0; blk_left[c] = 0; rd_cnt[c] = 0; cur_by[c] = 0; cur_la[c] = 0;
      for (int i = 0; i < 64; i++) mem[c][i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!ep_rd && st_wr == '0, "R1", "outputs in reset", {ep_rd, st_wr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ep_rd && st_wr == '0, "R1", "idle after reset", {ep_rd, st_wr}, 0);

    // A: four whole packets, pointer starts after 7
    clear_stats();
    load_pkt(1, 64); load_pkt(3, 64); load_pkt(4, 64); load_pkt(6, 64);
    wait_idle();
    exp_o = '{1, 3, 4, 6}; chk_order("R3");
    chk(gap_min == 2 && gap_max == 2, "R8", "idle gap between blocks", gap_min, 2);
    chk(rd_cnt[4] == 16, "R6", "beats of 64-byte block", rd_cnt[4], 16);

    // B: two-block packet shares with another endpoint
    clear_stats();
    load_pkt(2, 128); load_pkt(5, 64);
    wait_idle();
    exp_o = '{2, 5, 2}; chk_order("R3");
    chk(rd_cnt[2] == 32, "R6", "beats of 128-byte packet", rd_cnt[2], 32);

    // C: short blocks, pointer wraps past 7
    clear_stats();
    load_pkt(0, 10); load_pkt(7, 100);
    wait_idle();
    exp_o = '{7, 0, 7}; chk_order("R3");
    chk(rd_cnt[0] == 3, "R7", "beats of 10-byte packet", rd_cnt[0], 3);
    chk(rd_cnt[7] == 25, "R7", "beats of 100-byte packet", rd_cnt[7], 25);

    // D: room boundary 15 then 16
    clear_stats();
    free_m[3] = 15;
    load_pkt(3, 64); load_pkt(4, 64);
    wait_idle();
    chk(rd_cnt[3] == 0, "R9", "endpoint with 15 free not served", rd_cnt[3], 0);
    chk(rd_cnt[4] == 16, "R9", "other endpoint served", rd_cnt[4], 16);
    free_m[3] = 16;
    wait_idle();
    chk(rd_cnt[3] == 16, "R2", "endpoint with 16 free served", rd_cnt[3], 16);

    // E: request with zero bytes
    clear_stats();
    req_zero[5] = 1;
    repeat (40) @(negedge clk);
    chk(rd_cnt[5] == 0 && !ep_rd, "R9", "zero-byte request reads", rd_cnt[5], 0);
    req_zero[5] = 0;

    // F: request and room vanish mid-block
    clear_stats();
    load_pkt(1, 64);
    for (int t = 0; t < 50 && !ep_rd; t++) @(negedge clk);
    req_mask[1] = 1; free_m[1] = 0;
    wait_idle();
    chk(rd_cnt[1] == 16, "R4", "block completes after drop", rd_cnt[1], 16);
    req_mask[1] = 0; free_m[1] = 64;

    summary();
    $finish;
  end
endmodule